// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline Timing Sequencer

This block tracks instruction tokens as they pass through a scalar, in-order pipeline of five stages: fetch queue, first decode, address generation, execute, and retire. It models only timing and ordering. Each token carries a tag and three encoding attribute bits. Each stage holds a valid bit, the tag and the attributes of the token it contains.

Some encodings cost extra cycles. A token with a prefix stays one extra cycle in the first decode stage. A token with a complex address stays one extra cycle in address generation. A complex address means either base plus index, or displacement plus immediate. When a stage holds, every stage behind it holds too, and a bubble moves into the stage ahead of it. An external execute stall freezes the execute stage and everything behind it.

Tokens enter through a valid/ready handshake. The retire stage reports each token as it leaves, in fetch order.

Top module: `pipe5_seq`

## Requirements
- R1: A synchronous reset clears every stage. After reset, `done_valid` is 0, `in_ready` is 1, and no token that was in flight before the reset ever completes.
- R2: A token accepted at clock edge n with no extra cycles and no stall shows on `done_valid`/`done_tag` right after edge n+4. That is the fifth cycle, counting the acceptance cycle as the first.
- R3: Back-to-back tokens with no extra cycles complete on consecutive cycles, one per cycle.
- R4: A token with attribute bit 0 set (prefix) spends exactly one extra cycle in first decode. That token and every later token complete one cycle later.
- R5: A token with attribute bit 1 set (base plus index) spends exactly one extra cycle in address generation.
- R6: A token with attribute bit 2 set (displacement plus immediate) spends one extra cycle in address generation. Bits 1 and 2 set together still cost only one cycle.
- R7: If one token holds in address generation while the token behind it holds in first decode in the same cycle, the pair loses only one cycle.
- R8: Each cycle that `ex_stall` is high holds the execute stage and all stages behind it. The retire stage receives a bubble, so `done_valid` is 0 in the next cycle.
- R9: `in_ready` is 1 whenever the fetch slot is empty or can advance. It is 0 when the fetch slot is occupied and held. A token is taken only on an edge where `in_valid` and `in_ready` are both 1.
- R10: Tokens complete in acceptance order. Each completion is a one-cycle pulse of `done_valid` carrying the token's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A new token is offered |
| in_ready | output | 1 | The fetch slot can take a token at the next edge |
| in_tag | input | TAG_W | Tag of the offered token |
| in_attr | input | 3 | Encoding attributes: bit 0 prefix, bit 1 base plus index, bit 2 displacement plus immediate |
| ex_stall | input | 1 | Holds the execute stage and everything behind it |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | TAG_W | Tag of the completing token |

## Verification
A plain token accepted at a given edge shows at the retire outputs four edges later. Each prefix or complex-address penalty delays that token and every later one by exactly one edge. Each stalled cycle delays everything behind execute by one edge. `in_ready` is combinational and reflects the current cycle.

The bench counts edges from the release of reset. It logs every completion together with the edge count it followed. It compares each logged edge count with the value worked out by hand from these rules.

All outputs are sampled on the falling clock edge, half a cycle after the edge that updated them. For the overlap case, the expected value includes only one lost cycle.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int NSTG   = 5;
    localparam int ATTR_W = 3;

    localparam int STG_PF = 0;
    localparam int STG_D1 = 1;
    localparam int STG_AG = 2;
    localparam int STG_EX = 3;
    localparam int STG_RT = 4;

    localparam int ATTR_PFX = 0;
    localparam int ATTR_BIX = 1;
    localparam int ATTR_DIM = 2;

    // Attribute bits that cost an extra cycle in a given stage
    function automatic logic [ATTR_W-1:0] stage_xmask(input int stg);
        logic [ATTR_W-1:0] m;
        m = '0;
        if (stg == STG_D1) m[ATTR_PFX] = 1'b1;
        if (stg == STG_AG) begin
            m[ATTR_BIX] = 1'b1;
            m[ATTR_DIM] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pipe5_stage.sv
module pipe5_stage
    import pipe5_pkg::*;
#(
    parameter int               TAG_W = 8,
    parameter logic [ATTR_W-1:0] XMASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stay_i,
    input  logic              up_v_i,
    input  logic [TAG_W-1:0]  up_tag_i,
    input  logic [ATTR_W-1:0] up_attr_i,
    output logic              v_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [ATTR_W-1:0] attr_o,
    output logic              xhold_o
);

    typedef struct packed {
        logic              v;
        logic [TAG_W-1:0]  tag;
        logic [ATTR_W-1:0] attr;
        logic              xtra;
    } stg_t;

    stg_t stg_d, stg_q;
    logic xneed;

    always_comb begin
        xneed = stg_q.v && ((stg_q.attr & XMASK) != '0) && !stg_q.xtra;
        stg_d = stg_q;
        if (stay_i && stg_q.v) begin
            stg_d.xtra = stg_q.xtra | xneed;
        end else begin
            stg_d.v    = up_v_i;
            stg_d.tag  = up_tag_i;
            stg_d.attr = up_attr_i;
            stg_d.xtra = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= stg_d;
    end

    assign v_o     = stg_q.v;
    assign tag_o   = stg_q.tag;
    assign attr_o  = stg_q.attr;
    assign xhold_o = xneed;

    AST_XTRA_KEEPS_TOKEN: assert property (@(posedge clk) disable iff (rst)
        xhold_o |=> (stg_q.v && $stable(stg_q.tag))) else $error("extra cycle lost token"); // R4 R5 R6

    AST_XTRA_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (xhold_o && stay_i) |=> !xhold_o) else $error("extra cycle repeated"); // R6

endmodule

// File: rtl/pipe5_hold_ctl.sv
module pipe5_hold_ctl
    import pipe5_pkg::*;
(
    input  logic            ex_stall_i,
    input  logic [NSTG-1:0] xhold_i,
    input  logic            pf_v_i,
    output logic [NSTG-1:0] stay_o,
    output logic            in_ready_o
);

    assign stay_o[NSTG-1] = xhold_i[NSTG-1];

    for (genvar i = NSTG - 2; i >= 0; i--) begin : g_chain
        if (i == STG_EX) begin : g_ex
            assign stay_o[i] = xhold_i[i] | ex_stall_i | stay_o[i+1];
        end else begin : g_plain
            assign stay_o[i] = xhold_i[i] | stay_o[i+1];
        end
    end

    assign in_ready_o = !(pf_v_i && stay_o[STG_PF]);

endmodule

// File: rtl/pipe5_seq.sv
module pipe5_seq
    import pipe5_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [ATTR_W-1:0] in_attr,
    input  logic              ex_stall,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag
);

    logic [NSTG-1:0]   stg_v;
    logic [NSTG-1:0]   stay;
    logic [NSTG-1:0]   xhold;
    logic [TAG_W-1:0]  stg_tag  [NSTG];
    logic [ATTR_W-1:0] stg_attr [NSTG];

    pipe5_hold_ctl u_hold (
        .ex_stall_i (ex_stall),
        .xhold_i    (xhold),
        .pf_v_i     (stg_v[STG_PF]),
        .stay_o     (stay),
        .in_ready_o (in_ready)
    );

    for (genvar i = 0; i < NSTG; i++) begin : g_stg
        logic              up_v;
        logic [TAG_W-1:0]  up_tag;
        logic [ATTR_W-1:0] up_attr;

        if (i == 0) begin : g_head
            assign up_v    = in_valid;
            assign up_tag  = in_tag;
            assign up_attr = in_attr;
        end else begin : g_link
            assign up_v    = stg_v[i-1] && !stay[i-1];
            assign up_tag  = stg_tag[i-1];
            assign up_attr = stg_attr[i-1];
        end

        pipe5_stage #(
            .TAG_W (TAG_W),
            .XMASK (stage_xmask(i))
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .stay_i    (stay[i]),
            .up_v_i    (up_v),
            .up_tag_i  (up_tag),
            .up_attr_i (up_attr),
            .v_o       (stg_v[i]),
            .tag_o     (stg_tag[i]),
            .attr_o    (stg_attr[i]),
            .xhold_o   (xhold[i])
        );
    end

    assign done_valid = stg_v[STG_RT];
    assign done_tag   = stg_tag[STG_RT];

    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !stg_v[STG_PF] |-> in_ready) else $error("ready low with empty fetch"); // R9

    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (rst)
        (stg_v[STG_PF] && !in_ready) |=> (stg_v[STG_PF] && $stable(stg_tag[STG_PF]))) else $error("fetch slot lost"); // R9

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        ex_stall |=> !done_valid) else $error("retire during stall"); // R8

    AST_DONE_FROM_EX: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> ($past(stg_v[STG_EX]) && !$past(ex_stall))) else $error("completion without source"); // R2

endmodule

// File: tb/pipe5_seq_tb.sv
`timescale 1ns/1ps
module pipe5_seq_tb;

    localparam int TAG_W = 8;
    localparam int NV    = 10;
    // attribute bits: 1 prefix, 2 base+index, 4 disp+imm
    localparam int V_ATTR [NV] = '{0, 1, 0, 2, 0, 4, 6, 3, 0, 0};
    // completion edge counted from reset release, token k offered back-to-back
    localparam int V_EXP  [NV] = '{5, 7, 8, 10, 11, 13, 15, 17, 18, 19};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [TAG_W-1:0] in_tag = '0;
    logic [2:0]       in_attr = '0;
    logic             ex_stall = 1'b0;
    logic             done_valid;
    logic [TAG_W-1:0] done_tag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int n_done = 0;
    int log_cyc [64];
    logic [TAG_W-1:0] log_tag [64];

    pipe5_seq #(.TAG_W(TAG_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_tag     (in_tag),
        .in_attr    (in_attr),
        .ex_stall   (ex_stall),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && done_valid && n_done < 64) begin
            log_cyc[n_done] = cyc;
            log_tag[n_done] = done_tag;
            n_done = n_done + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input int k);
        case (V_ATTR[k])
            1: return "R4 prefix";
            2: return "R5 base+index";
            4: return "R6 disp+imm";
            6: return "R6 both bits single cycle";
            3: return "R7 overlap";
            default: return "R2 R3 plain";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        ex_stall = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic [TAG_W-1:0] t, input logic [2:0] a);
        logic acc;
        in_valid = 1'b1;
        in_tag   = t;
        in_attr  = a;
        forever begin
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int base_c;
        int base_n;

        // R1: reset state
        do_reset();
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        chk(done_valid == 1'b0, "R1 no completion after reset", done_valid, 0);

        // table walk: back-to-back stream with extra cycles
        base_c = cyc;
        base_n = n_done;
        for (int k = 0; k < NV; k++) send(TAG_W'(8'h10 + k), 3'(V_ATTR[k]));
        in_valid = 1'b0;
        repeat (25) @(negedge clk);
        chk(n_done - base_n == NV, "R10 completion count", n_done - base_n, NV);
        for (int k = 0; k < NV; k++) begin
            chk(log_tag[base_n + k] == TAG_W'(8'h10 + k), "R10 order", log_tag[base_n + k], 8'h10 + k);
            chk(log_cyc[base_n + k] - base_c == V_EXP[k], req_of(k), log_cyc[base_n + k] - base_c, V_EXP[k]);
        end

        // R8: execute stall for three cycles on a single token
        do_reset();
        base_c = cyc;
        base_n = n_done;
        send(8'hA1, 3'd0);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        ex_stall = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(done_valid == 1'b0, "R8 bubble during stall", done_valid, 0);
        end
        ex_stall = 1'b0;
        repeat (4) @(negedge clk);
        chk(n_done - base_n == 1, "R10 single pulse", n_done - base_n, 1);
        chk(log_cyc[base_n] - base_c == 8, "R8 stall delay", log_cyc[base_n] - base_c, 8);
        chk(log_tag[base_n] == 8'hA1, "R8 tag", log_tag[base_n], 8'hA1);

        // R9: backpressure while stalled from the start
        do_reset();
        base_c = cyc;
        base_n = n_done;
        ex_stall = 1'b1;
        in_valid = 1'b1;
        in_tag = 8'hB1;
        in_attr = 3'd0;
        chk(in_ready == 1'b1, "R9 ready with empty fetch", in_ready, 1);
        @(negedge clk);
        in_tag = 8'hB2;
        repeat (3) begin
            chk(in_ready == 1'b0, "R9 ready low when held", in_ready, 0);
            @(negedge clk);
        end
        ex_stall = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R9 ready after release", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(n_done - base_n == 2, "R9 two completions", n_done - base_n, 2);
        chk(log_tag[base_n] == 8'hB1, "R10 first tag", log_tag[base_n], 8'hB1);
        chk(log_tag[base_n + 1] == 8'hB2, "R10 second tag", log_tag[base_n + 1], 8'hB2);
        chk(log_cyc[base_n] - base_c == 8, "R9 first timing", log_cyc[base_n] - base_c, 8);
        chk(log_cyc[base_n + 1] - base_c == 9, "R9 second timing", log_cyc[base_n + 1] - base_c, 9);

        // R1: reset with tokens in flight
        do_reset();
        send(8'hC1, 3'd1);
        send(8'hC2, 3'd0);
        send(8'hC3, 3'd2);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        base_n = n_done;
        chk(in_ready == 1'b1, "R1 ready after mid-flight reset", in_ready, 1);
        repeat (10) @(negedge clk);
        chk(n_done - base_n == 0, "R1 flushed tokens never complete", n_done - base_n, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule